// File: doc/BRIEF.md
# Peripheral DMA Channel with Address/Count Reload

This block is one channel of a peripheral DMA engine. Software programs a memory address and a transfer count, chooses which peripheral request line paces the channel, picks byte or halfword units, and enables it. For every request raised on the chosen line, the channel issues one memory access at the current address. When that access completes, it acknowledges the peripheral, advances the address by the unit size and lowers the count by one.

A second address/count pair acts as a reload slot. When the active count reaches zero while the reload count is nonzero, the channel copies the reload pair into the active pair and empties the reload count. Software can therefore queue the next buffer while the current one is still running, and the channel never stops between buffers.

Three status flags report progress. Reload-empty shows that the slot can take a new buffer. Complete shows that all programmed work is done. Error records a failed memory access, which also halts the channel. Each flag has an interrupt mask bit that software sets and clears with separate write-one registers, and the interrupt output is the OR of the flags that are unmasked.

Top module: `pdma_chan`

## Requirements
- R1: After reset the channel is disabled, the address, count, reload address, reload count and interrupt mask read as zero, `irq` is low, and the flag register reads 3 (reload-empty and complete set, error clear).
- R2: A unit starts only while the channel is enabled and the count is nonzero. The access drives `mem_req` with `mem_addr` equal to the current address. When it completes without error, the count drops by one and `periph_ack` pulses high for exactly one cycle, on the selected line only.
- R3: The unit size is bit 0 of the mode register (offset 5): 0 gives byte units and 1 gives halfword units. `mem_size` follows this bit, and the address advances by 1 or 2 after each completed unit.
- R4: Only the request line whose index is held in the select register (offset 4) can start a unit. Requests on any other line are ignored and are never acknowledged.
- R5: When the count (offset 1) is zero and the reload count (offset 3) is nonzero, the next clock edge loads the address from the reload address (offset 2), loads the count from the reload count, and clears the reload count. This reload takes priority over a register write made in the same cycle.
- R6: Flag bit 0 of the flag register (offset 11), reload-empty, is set exactly when the reload count is zero.
- R7: Flag bit 1, complete, is set exactly when both the count and the reload count are zero. A memory error never raises complete.
- R8: An access that ends with `mem_err` sets flag bit 2 (error) and disables the channel. The address and count keep their values.
- R9: While the error flag is set, the enable command is ignored. Control bit 2 (offset 6) clears the error flag.
- R10: Control register writes use bit 0 to enable and bit 1 to disable; when both bits are written together, disable wins. Bit 0 of the state register (offset 7) reads 1 while the channel is enabled. A disabled channel starts no unit.
- R11: Writing ones to offset 8 sets those interrupt mask bits, and writing ones to offset 9 clears them. Offset 10 reads the mask. `irq` equals the OR of (flags AND mask).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| periph_req | input | NPER | Peripheral request lines |
| periph_ack | output | NPER | Peripheral acknowledge lines |
| mem_req | output | 1 | Memory access request, held until `mem_ready` |
| mem_addr | output | AW | Memory access address |
| mem_size | output | 1 | Access size: 0 byte, 1 halfword |
| mem_ready | input | 1 | Memory access completed |
| mem_err | input | 1 | Completed access failed, qualified by `mem_ready` |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume a well-behaved peripheral and memory. A peripheral keeps its request high until it is acknowledged. `mem_ready` is raised only while `mem_req` is high. The select register is left alone while a unit is in flight, so an acknowledge always lands on the line that started the unit. The bench meets these assumptions in its models. The memory responder answers each access after exactly one cycle and raises an error only when a test asks for one. The peripheral models lower their request on the acknowledge and raise it again only for the next request that was issued. Every select, count or mode change is made while the channel is idle or disabled.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
// Shared constants for the peripheral DMA channel: register offsets,
// command and flag bit positions, and the engine state type.
package pdma_pkg;
    localparam int DW = 32;                 // register data width
    localparam int RAW = 4;                 // register offset width

    localparam logic [RAW-1:0] OFS_ADDR  = 4'd0;
    localparam logic [RAW-1:0] OFS_CNT   = 4'd1;
    localparam logic [RAW-1:0] OFS_RADDR = 4'd2;
    localparam logic [RAW-1:0] OFS_RCNT  = 4'd3;
    localparam logic [RAW-1:0] OFS_PSEL  = 4'd4;
    localparam logic [RAW-1:0] OFS_MODE  = 4'd5;
    localparam logic [RAW-1:0] OFS_CTRL  = 4'd6;
    localparam logic [RAW-1:0] OFS_STATE = 4'd7;
    localparam logic [RAW-1:0] OFS_IEN   = 4'd8;
    localparam logic [RAW-1:0] OFS_IDIS  = 4'd9;
    localparam logic [RAW-1:0] OFS_IMASK = 4'd10;
    localparam logic [RAW-1:0] OFS_FLAGS = 4'd11;

    localparam int CMD_EN   = 0;
    localparam int CMD_DIS  = 1;
    localparam int CMD_ECLR = 2;

    localparam int NFLAG    = 3;
    localparam int FLG_RCZ  = 0;
    localparam int FLG_DONE = 1;
    localparam int FLG_ERR  = 2;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_XFER = 2'd1,
        ENG_ACK  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/pdma_regs.sv
`timescale 1ns/1ps
// Register bank of the channel. Holds the active and reload address/count
// pairs, select, mode, enable, error and interrupt mask. Applies unit steps
// and error events from the engine and performs the automatic reload.
// Assumes step and err_evt are never high together, and that step occurs
// only while the count is nonzero.
module pdma_regs
    import pdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int PW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [RAW-1:0]   waddr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [NFLAG-1:0] flags,
    input  logic             step,
    input  logic             err_evt,
    output logic [AW-1:0]    cur_addr,
    output logic [CW-1:0]    cur_cnt,
    output logic             size,
    output logic [PW-1:0]    psel,
    output logic             en,
    output logic             terr,
    output logic [NFLAG-1:0] mask,
    output logic             cnt_zero,
    output logic             rcnt_zero
);
    logic [AW-1:0] raddr;
    logic [CW-1:0] rcnt;
    logic [AW-1:0] inc;
    logic          reload_go;
    logic          unused_wbits;

    // zero tests, reload condition and address step size
    assign cnt_zero     = (cur_cnt == '0);
    assign rcnt_zero    = (rcnt == '0);
    assign reload_go    = cnt_zero && !rcnt_zero;
    assign inc          = {{(AW-2){1'b0}}, size, ~size};
    assign unused_wbits = ^wdata;

    // active address and count: unit step, then reload, then software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
        end else if (step) begin
            cur_addr <= cur_addr + inc;
            cur_cnt  <= cur_cnt - 1'b1;
        end else if (reload_go) begin
            cur_addr <= raddr;
            cur_cnt  <= rcnt;
        end else if (wr) begin
            if (waddr == OFS_ADDR) cur_addr <= wdata[AW-1:0];
            if (waddr == OFS_CNT)  cur_cnt  <= wdata[CW-1:0];
        end
    end

    // reload pair: emptied on reload, else written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raddr <= '0;
            rcnt  <= '0;
        end else begin
            if (wr && waddr == OFS_RADDR) raddr <= wdata[AW-1:0];
            if (reload_go)                     rcnt <= '0;
            else if (wr && waddr == OFS_RCNT)  rcnt <= wdata[CW-1:0];
        end
    end

    // select and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psel <= '0;
            size <= 1'b0;
        end else if (wr) begin
            if (waddr == OFS_PSEL) psel <= wdata[PW-1:0];
            if (waddr == OFS_MODE) size <= wdata[0];
        end
    end

    // enable and error flag driven by commands and engine error events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            terr <= 1'b0;
        end else if (err_evt) begin
            en   <= 1'b0;
            terr <= 1'b1;
        end else if (wr && waddr == OFS_CTRL) begin
            if (wdata[CMD_DIS])              en <= 1'b0;
            else if (wdata[CMD_EN] && !terr) en <= 1'b1;
            if (wdata[CMD_ECLR])             terr <= 1'b0;
        end
    end

    // interrupt mask with write-one-set and write-one-clear ports
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr && waddr == OFS_IEN) begin
            mask <= mask | wdata[NFLAG-1:0];
        end else if (wr && waddr == OFS_IDIS) begin
            mask <= mask & ~wdata[NFLAG-1:0];
        end
    end

    // read multiplexer, zero-extended to the data width
    always_comb begin
        rdata = '0;
        case (waddr)
            OFS_ADDR:  rdata[AW-1:0]    = cur_addr;
            OFS_CNT:   rdata[CW-1:0]    = cur_cnt;
            OFS_RADDR: rdata[AW-1:0]    = raddr;
            OFS_RCNT:  rdata[CW-1:0]    = rcnt;
            OFS_PSEL:  rdata[PW-1:0]    = psel;
            OFS_MODE:  rdata[0]         = size;
            OFS_STATE: rdata[0]         = en;
            OFS_IMASK: rdata[NFLAG-1:0] = mask;
            OFS_FLAGS: rdata[NFLAG-1:0] = flags;
            default:   rdata            = '0;
        endcase
    end
endmodule

// File: rtl/pdma_engine.sv
`timescale 1ns/1ps
// Transfer sequencer. Waits for a request on the selected line while the
// channel is enabled with work left, runs one memory access, then
// acknowledges the peripheral for one cycle. Assumes the select value
// stays stable while a unit is in flight.
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int NPER = 4,
    parameter int PW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            cnt_zero,
    input  logic [PW-1:0]   psel,
    input  logic [NPER-1:0] periph_req,
    input  logic            mem_ready,
    input  logic            mem_err,
    output logic            mem_req,
    output logic [NPER-1:0] periph_ack,
    output logic            step,
    output logic            err_evt
);
    eng_state_t state;
    logic       start;

    // a unit starts on a selected request when enabled with work left
    assign start   = en && !cnt_zero && periph_req[psel];
    assign mem_req = (state == ENG_XFER);
    assign step    = mem_req && mem_ready && !mem_err;
    assign err_evt = mem_req && mem_ready && mem_err;

    // sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENG_IDLE;
        end else begin
            case (state)
                ENG_IDLE: if (start) state <= ENG_XFER;
                ENG_XFER: begin
                    if (err_evt)   state <= ENG_IDLE;
                    else if (step) state <= ENG_ACK;
                end
                ENG_ACK:  state <= ENG_IDLE;
                default:  state <= ENG_IDLE;
            endcase
        end
    end

    // one acknowledge line per peripheral, active only for the selected one
    for (genvar i = 0; i < NPER; i++) begin : g_ack
        assign periph_ack[i] = (state == ENG_ACK) && (psel == PW'(i));
    end
endmodule

// File: rtl/pdma_irq.sv
`timescale 1ns/1ps
// Status flag formation and interrupt output. Reload-empty follows the
// reload count, complete needs both counts at zero, error is the sticky
// error bit held in the register bank.
module pdma_irq
    import pdma_pkg::*;
(
    input  logic             cnt_zero,
    input  logic             rcnt_zero,
    input  logic             terr,
    input  logic [NFLAG-1:0] mask,
    output logic [NFLAG-1:0] flags,
    output logic             irq
);
    // flag vector and masked interrupt reduction
    always_comb begin
        flags           = '0;
        flags[FLG_RCZ]  = rcnt_zero;
        flags[FLG_DONE] = cnt_zero && rcnt_zero;
        flags[FLG_ERR]  = terr;
        irq             = |(flags & mask);
    end
endmodule

// File: rtl/pdma_chan.sv
`timescale 1ns/1ps
// Top of one peripheral DMA channel with address/count reload. Joins the
// register bank, the transfer sequencer and the flag/interrupt logic.
// Assumes mem_ready is raised only while mem_req is high.
module pdma_chan
    import pdma_pkg::*;
#(
    parameter int AW   = 32,
    parameter int CW   = 16,
    parameter int NPER = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [3:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic [NPER-1:0] periph_req,
    output logic [NPER-1:0] periph_ack,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_size,
    input  logic            mem_ready,
    input  logic            mem_err,
    output logic            irq
);
    localparam int PW = (NPER > 1) ? $clog2(NPER) : 1;

    logic [AW-1:0]    cur_addr;
    logic [CW-1:0]    cur_cnt;
    logic             size;
    logic [PW-1:0]    psel;
    logic             en;
    logic             terr;
    logic [NFLAG-1:0] mask;
    logic [NFLAG-1:0] flags;
    logic             cnt_zero;
    logic             rcnt_zero;
    logic             step;
    logic             err_evt;

    // memory address and size come straight from the active registers
    assign mem_addr = cur_addr;
    assign mem_size = size;

    pdma_regs #(.AW(AW), .CW(CW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .flags(flags),
        .step(step), .err_evt(err_evt), .cur_addr(cur_addr),
        .cur_cnt(cur_cnt), .size(size), .psel(psel), .en(en),
        .terr(terr), .mask(mask), .cnt_zero(cnt_zero),
        .rcnt_zero(rcnt_zero)
    );

    pdma_engine #(.NPER(NPER), .PW(PW)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(en), .cnt_zero(cnt_zero),
        .psel(psel), .periph_req(periph_req), .mem_ready(mem_ready),
        .mem_err(mem_err), .mem_req(mem_req), .periph_ack(periph_ack),
        .step(step), .err_evt(err_evt)
    );

    pdma_irq u_irq (
        .cnt_zero(cnt_zero), .rcnt_zero(rcnt_zero), .terr(terr),
        .mask(mask), .flags(flags), .irq(irq)
    );
endmodule

// File: rtl/pdma_chan_chk.sv
`timescale 1ns/1ps
// Property checker for the channel, attached to the top by bind.
module pdma_chan_chk #(
    parameter int NPER = 4,
    parameter int PW   = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NPER-1:0] periph_ack,
    input logic [PW-1:0]   psel,
    input logic            mem_req,
    input logic            mem_ready,
    input logic            mem_err,
    input logic            en,
    input logic            terr,
    input logic            cnt_zero,
    input logic            rcnt_zero,
    input logic [2:0]      flags,
    input logic [2:0]      mask,
    input logic            irq
);
    // R2
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(periph_ack));
    // R4
    ack_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_ack) |-> periph_ack[psel]);
    // R2
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(en && !cnt_zero));
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_zero && !rcnt_zero) |=> (rcnt_zero && !cnt_zero));
    // R8
    err_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_err) |=> (!en && terr));
    // R9
    en_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (terr && !en) |=> !en);
    // R7
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($rose(flags[2]) && $rose(flags[1])));
    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 3'b000) |-> !irq);
endmodule

bind pdma_chan pdma_chan_chk #(.NPER(NPER), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .periph_ack(periph_ack), .psel(psel),
    .mem_req(mem_req), .mem_ready(mem_ready), .mem_err(mem_err),
    .en(en), .terr(terr), .cnt_zero(cnt_zero), .rcnt_zero(rcnt_zero),
    .flags(flags), .mask(mask), .irq(irq)
);

// File: tb/sim_pdma_chan.sv
`timescale 1ns/1ps
module sim_pdma_chan;
    localparam int NPER = 4;
    localparam int AW   = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr = 1'b0;
    logic [3:0]      reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NPER-1:0] periph_req = '0;
    logic [NPER-1:0] periph_ack;
    logic            mem_req;
    logic [AW-1:0]   mem_addr;
    logic            mem_size;
    logic            mem_ready = 1'b0;
    logic            mem_err = 1'b0;
    logic            irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit err_inject = 1'b0;
    int issued[NPER];
    int raised[NPER];
    int acked[NPER];
    logic [AW:0] exp_q[$];

    always #5 clk = ~clk;

    pdma_chan u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .periph_req(periph_req), .periph_ack(periph_ack),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_ready(mem_ready), .mem_err(mem_err), .irq(irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_reg(string tag, logic [3:0] a, logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic expect_unit(logic sz, logic [AW-1:0] a);
        exp_q.push_back({sz, a});
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // memory responder and scoreboard monitor: one-cycle response per access
    always @(negedge clk) begin
        if (rst_n && mem_req && !mem_ready) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected access: actual %0h expected none", mem_addr);
            end else begin
                logic [AW:0] e;
                e = exp_q.pop_front();
                if ({mem_size, mem_addr} !== e) begin
                    n_fail++;
                    $display("FAIL R2/R3 access: actual %0h expected %0h", {mem_size, mem_addr}, e);
                end
            end
            mem_ready = 1'b1;
            mem_err   = err_inject;
        end else begin
            mem_ready = 1'b0;
            mem_err   = 1'b0;
        end
    end

    // peripheral models: hold request until acknowledged
    always @(negedge clk) begin
        for (int i = 0; i < NPER; i++) begin
            if (periph_ack[i]) begin
                periph_req[i] = 1'b0;
                acked[i]++;
            end else if (!periph_req[i] && raised[i] < issued[i]) begin
                periph_req[i] = 1'b1;
                raised[i]++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NPER; i++) begin
            issued[i] = 0; raised[i] = 0; acked[i] = 0;
        end
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        chk_reg("R1 flags", 4'd11, 32'd3);
        chk_reg("R1 state", 4'd7, 32'd0);
        chk_reg("R1 mask", 4'd10, 32'd0);
        chk_reg("R1 count", 4'd1, 32'd0);
        chk_reg("R1 reload count", 4'd3, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // byte transfers on line 1, line 0 ignored
        wr(4'd5, 32'd0);
        wr(4'd4, 32'd1);
        wr(4'd0, 32'h1000);
        wr(4'd1, 32'd3);
        chk_reg("R7 flags with work", 4'd11, 32'd1);
        wr(4'd6, 32'd1);
        chk_reg("R10 enabled", 4'd7, 32'd1);
        issued[0]++;
        idle(20);
        chk("R4 no ack line0", acked[0], 32'd0);
        chk_reg("R4 count held", 4'd1, 32'd3);
        expect_unit(1'b0, 32'h1000);
        expect_unit(1'b0, 32'h1001);
        expect_unit(1'b0, 32'h1002);
        issued[1] += 3;
        idle(40);
        chk_reg("R2 count drained", 4'd1, 32'd0);
        chk_reg("R3 byte address", 4'd0, 32'h1003);
        chk("R2 acks line1", acked[1], 32'd3);
        chk_reg("R7 complete", 4'd11, 32'd3);

        // halfword transfers with chained reload
        wr(4'd5, 32'd1);
        wr(4'd0, 32'h2000);
        wr(4'd1, 32'd2);
        wr(4'd2, 32'h3000);
        wr(4'd3, 32'd1);
        chk_reg("R6 reload full", 4'd11, 32'd0);
        expect_unit(1'b1, 32'h2000);
        expect_unit(1'b1, 32'h2002);
        expect_unit(1'b1, 32'h3000);
        issued[1] += 3;
        idle(50);
        chk_reg("R5 address after reload", 4'd0, 32'h3002);
        chk_reg("R5 count after reload", 4'd1, 32'd0);
        chk_reg("R5 reload emptied", 4'd3, 32'd0);
        chk_reg("R6 flags", 4'd11, 32'd3);
        chk("R2 acks after reload", acked[1], 32'd6);

        // immediate reload when the count is already zero
        wr(4'd2, 32'h4000);
        wr(4'd3, 32'd5);
        chk_reg("R5 immediate count", 4'd1, 32'd5);
        chk_reg("R5 immediate address", 4'd0, 32'h4000);
        chk_reg("R5 immediate reload", 4'd3, 32'd0);

        // memory error
        err_inject = 1'b1;
        wr(4'd8, 32'd4);
        expect_unit(1'b1, 32'h4000);
        issued[1]++;
        idle(20);
        chk_reg("R8 flags", 4'd11, 32'd5);
        chk("R11 irq on error", {31'd0, irq}, 32'd1);
        chk_reg("R8 count kept", 4'd1, 32'd5);
        chk_reg("R8 address kept", 4'd0, 32'h4000);
        chk_reg("R8 halted", 4'd7, 32'd0);
        chk("R8 no ack", acked[1], 32'd6);
        err_inject = 1'b0;
        wr(4'd6, 32'd1);
        chk_reg("R9 enable ignored", 4'd7, 32'd0);
        wr(4'd6, 32'd4);
        chk_reg("R9 error cleared", 4'd11, 32'd1);
        chk("R11 irq after clear", {31'd0, irq}, 32'd0);
        expect_unit(1'b1, 32'h4000);
        wr(4'd6, 32'd1);
        idle(20);
        chk_reg("R9 resumed count", 4'd1, 32'd4);
        chk_reg("R9 resumed address", 4'd0, 32'h4002);
        chk("R9 resumed ack", acked[1], 32'd7);

        // disable command and priority
        wr(4'd6, 32'd2);
        chk_reg("R10 disabled", 4'd7, 32'd0);
        issued[1]++;
        idle(20);
        chk_reg("R10 no unit when disabled", 4'd1, 32'd4);
        wr(4'd6, 32'd3);
        chk_reg("R10 disable wins", 4'd7, 32'd0);
        expect_unit(1'b1, 32'h4002);
        wr(4'd6, 32'd1);
        idle(20);
        chk_reg("R10 pending served", 4'd1, 32'd3);
        wr(4'd6, 32'd2);

        // interrupt mask set and clear
        wr(4'd8, 32'd3);
        chk_reg("R11 mask set", 4'd10, 32'd7);
        chk("R11 irq reload-empty", {31'd0, irq}, 32'd1);
        wr(4'd9, 32'd7);
        chk_reg("R11 mask clear", 4'd10, 32'd0);
        chk("R11 irq masked", {31'd0, irq}, 32'd0);
        wr(4'd8, 32'd2);
        chk_reg("R11 mask complete only", 4'd10, 32'd2);
        chk("R11 irq not complete", {31'd0, irq}, 32'd0);

        chk("R2 scoreboard drained", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule